// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the modem-side control and status registers of one asynchronous serial channel. It takes the two active-low handshake inputs from the line side, clear-to-send and data-set-ready, through a synchronizer. It shows their asserted state in a status register and latches a sticky change flag for each. A status read returns the flags and clears them. A control register drives the active-low data-terminal-ready and request-to-send outputs. The same register holds a loop-test mode bit and an enable for the channel's interrupt pin.

The interrupt pin is the OR of the modem-status request and any number of request lines from the channel's other logic. The control-register enable gates it. The modem-status request is raised while a change flag is set and the enable for it, which the channel's interrupt-enable logic supplies, is high. Reading the status register services the request.

Top module: `modem_stat_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00 (with both handshake inputs high), dtr_no and rts_no are 1, and irq_o is 0.
- R2: Status bit 4 shows the complement of cts_ni and bit 5 the complement of dsr_ni, two clock cycles after the input changes. Status bits 7:6 and 3:2 read 0.
- R3: Status bit 0 (CTS) and bit 1 (DSR) are set by any change of the state shown in bit 4 and bit 5 respectively. They stay set until a status read.
- R4: A status read (reg_addr_i = 1) returns the flags and clears them at that clock edge. A change that lands in the same cycle as the read leaves its flag set.
- R5: dtr_no is 0 exactly when control bit 0 is 1 and control bit 4 (loop) is 0. rts_no is 0 exactly when control bit 1 is 1 and bit 4 is 0. Both follow the write at the same clock edge as the register.
- R6: In loop mode (control bit 4 = 1), status bit 4 shows control bit 1 and status bit 5 shows control bit 0. The external handshake inputs are ignored and set no flag.
- R7: A control write (reg_addr_i = 0) stores write-data bits 4:0. A control read returns them with bits 7:5 zero.
- R8: irq_o is 1 exactly when control bit 3 is 1 and either msi_en_i is 1 with a change flag set, or any ext_req_i line is 1. When control bit 3 is 0, irq_o is 0.
- R9: A status read with no new change withdraws the modem-status request, so irq_o falls by the next cycle unless an ext_req_i line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe, one cycle per read |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data of the selected register, combinational |
| cts_ni | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_ni | input | 1 | Data-set-ready, active low, asynchronous |
| msi_en_i | input | 1 | Modem-status interrupt enable from the channel |
| ext_req_i | input | NUM_EXT_REQ | Other interrupt requests of the channel |
| dtr_no | output | 1 | Data-terminal-ready, active low |
| rts_no | output | 1 | Request-to-send, active low |
| irq_o | output | 1 | Channel interrupt, active high |

## Verification
The hardest case is a handshake change whose edge detection falls in the same clock cycle as the status read that clears the flags. Only that alignment shows whether a new change wins over the clear. The bench reaches it by counting the synchronizer latency. It moves an input on a falling edge and waits one more falling edge. It then asserts the read strobe, so the read's clock edge is the one at which the synchronized level first differs from the stored one. A second read confirms that the flag survived. Loop mode gets the same care: the bench moves the external inputs while the loop is on and shows through a later status read that they left no flag.

// File: rtl/modem_reg_pkg.sv
package modem_reg_pkg;

   localparam int CTRL_W      = 5;
   localparam int CTRL_DTR    = 0;
   localparam int CTRL_RTS    = 1;
   localparam int CTRL_OUTEN  = 3;
   localparam int CTRL_LOOP   = 4;

   localparam int STAT_DCTS   = 0;
   localparam int STAT_DDSR   = 1;
   localparam int STAT_CTS    = 4;
   localparam int STAT_DSR    = 5;
   localparam int STAT_MIN_W  = 6;

   localparam int NUM_LINES   = 2;
   localparam int LINE_CTS    = 0;
   localparam int LINE_DSR    = 1;

   typedef enum logic {
      ADDR_CTRL = 1'b0,
      ADDR_STAT = 1'b1
   } reg_addr_e;

   typedef struct packed {
      logic loop;
      logic out_en;
      logic spare;
      logic rts;
      logic dtr;
   } ctrl_t;

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("modem_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= RST_VAL;
            else         chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= RST_VAL;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/modem_change_track.sv
module modem_change_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   input  logic clr_i,
   output logic flag_o,
   output logic change_o
);

   logic prev_q;
   logic flag_q;

   assign change_o = level_i ^ prev_q;
   assign flag_o   = flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= level_i;
         flag_q <= change_o | (flag_q & ~clr_i);
      end
   end

   AST_FLAG_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      change_o |=> flag_o); // R3
   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o); // R3
   AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !change_o) |=> !flag_o); // R4

endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
   import modem_reg_pkg::*;
#(
   parameter bit REG_OUTPUTS = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output ctrl_t             ctrl_o,
   output logic              dtr_no,
   output logic              rts_no
);

   ctrl_t ctrl_q;
   ctrl_t ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_en_i) ctrl_d = ctrl_t'(wdata_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q <= '0;
      else         ctrl_q <= ctrl_d;
   end

   assign ctrl_o = ctrl_q;

   if (REG_OUTPUTS) begin : g_reg_out
      logic dtr_q;
      logic rts_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            dtr_q <= 1'b1;
            rts_q <= 1'b1;
         end else begin
            dtr_q <= ~(ctrl_d.dtr & ~ctrl_d.loop);
            rts_q <= ~(ctrl_d.rts & ~ctrl_d.loop);
         end
      end
      assign dtr_no = dtr_q;
      assign rts_no = rts_q;
   end else begin : g_comb_out
      assign dtr_no = ~(ctrl_q.dtr & ~ctrl_q.loop);
      assign rts_no = ~(ctrl_q.rts & ~ctrl_q.loop);
   end

endmodule

// File: rtl/modem_stat_ctrl.sv
module modem_stat_ctrl
   import modem_reg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_EXT_REQ = 2,
   parameter bit LOOPBACK_EN = 1'b1,
   parameter bit REG_OUTPUTS = 1'b1
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   reg_addr_i,
   input  logic                   reg_wr_i,
   input  logic                   reg_rd_i,
   input  logic [DATA_W-1:0]      reg_wdata_i,
   output logic [DATA_W-1:0]      reg_rdata_o,
   input  logic                   cts_ni,
   input  logic                   dsr_ni,
   input  logic                   msi_en_i,
   input  logic [NUM_EXT_REQ-1:0] ext_req_i,
   output logic                   dtr_no,
   output logic                   rts_no,
   output logic                   irq_o
);

   if (DATA_W < STAT_MIN_W || DATA_W < CTRL_W) begin : g_bad_width
      $error("modem_stat_ctrl: DATA_W too narrow for the register fields");
   end
   if (NUM_EXT_REQ < 1) begin : g_bad_req
      $error("modem_stat_ctrl: NUM_EXT_REQ must be at least 1");
   end

   localparam int HI_W = DATA_W - CTRL_W;

   ctrl_t                ctrl_q;
   logic                 ctrl_wr;
   logic                 stat_rd;
   logic [NUM_LINES-1:0] line_n;
   logic [NUM_LINES-1:0] loop_src;
   logic [NUM_LINES-1:0] line_sync_n;
   logic [NUM_LINES-1:0] shown;
   logic [NUM_LINES-1:0] flag;
   logic [NUM_LINES-1:0] change;
   logic                 msr_req;
   logic                 unused_wdata_hi;

   assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);
   assign stat_rd = reg_rd_i && (reg_addr_i == ADDR_STAT);
   assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:DATA_W-HI_W];

   modem_ctrl_reg #(
      .REG_OUTPUTS (REG_OUTPUTS)
   ) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (ctrl_wr),
      .wdata_i (reg_wdata_i[CTRL_W-1:0]),
      .ctrl_o  (ctrl_q),
      .dtr_no  (dtr_no),
      .rts_no  (rts_no)
   );

   assign line_n[LINE_CTS]   = cts_ni;
   assign line_n[LINE_DSR]   = dsr_ni;
   assign loop_src[LINE_CTS] = ctrl_q.rts;
   assign loop_src[LINE_DSR] = ctrl_q.dtr;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      modem_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (1'b1)
      ) u_sync (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .async_i (line_n[l]),
         .sync_o  (line_sync_n[l])
      );

      if (LOOPBACK_EN) begin : g_loop
         assign shown[l] = ctrl_q.loop ? loop_src[l] : ~line_sync_n[l];
      end else begin : g_direct
         logic unused_loop_src;
         assign unused_loop_src = loop_src[l];
         assign shown[l] = ~line_sync_n[l];
      end

      modem_change_track u_track (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .level_i  (shown[l]),
         .clr_i    (stat_rd),
         .flag_o   (flag[l]),
         .change_o (change[l])
      );
   end

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == ADDR_CTRL) begin
         reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      end else begin
         reg_rdata_o[STAT_DCTS] = flag[LINE_CTS];
         reg_rdata_o[STAT_DDSR] = flag[LINE_DSR];
         reg_rdata_o[STAT_CTS]  = shown[LINE_CTS];
         reg_rdata_o[STAT_DSR]  = shown[LINE_DSR];
      end
   end

   assign msr_req = msi_en_i & (|flag);
   assign irq_o   = ctrl_q.out_en & (msr_req | (|ext_req_i));

   AST_DTR_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr |=> (dtr_no == !($past(reg_wdata_i[CTRL_DTR]) && !$past(reg_wdata_i[CTRL_LOOP])))); // R5
   AST_RTS_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr |=> (rts_no == !($past(reg_wdata_i[CTRL_RTS]) && !$past(reg_wdata_i[CTRL_LOOP])))); // R5
   AST_IRQ_GATED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && !reg_wdata_i[CTRL_OUTEN]) |=> !irq_o); // R8
   AST_IRQ_SERVICED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_rd && !(|change)) |=> (!irq_o || (|ext_req_i))); // R9
   AST_LOOP_NO_EXT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q.loop && !ctrl_wr && !reg_wr_i && stat_rd) |=> (flag == '0)); // R6

endmodule

// File: tb/modem_stat_ctrl_tb_top.sv
module modem_stat_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       cts_n = 1'b1;
   logic       dsr_n = 1'b1;
   logic       msi_en = 1'b0;
   logic [1:0] ext_req = '0;
   logic       dtr_n;
   logic       rts_n;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   modem_stat_ctrl dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_addr_i  (addr),
      .reg_wr_i    (wr),
      .reg_rd_i    (rd),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .cts_ni      (cts_n),
      .dsr_ni      (dsr_n),
      .msi_en_i    (msi_en),
      .ext_req_i   (ext_req),
      .dtr_no      (dtr_n),
      .rts_no      (rts_n),
      .irq_o       (irq)
   );

   typedef struct packed {
      logic       cts_n;
      logic       dsr_n;
      logic [4:0] ctrl;
      logic       msi;
      logic [1:0] ext;
      logic [7:0] stat;
      logic       dtr_n;
      logic       rts_n;
      logic       irq;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b1, 5'h08, 1'b1, 2'b00, 8'h11, 1'b1, 1'b1, 1'b1},
      '{1'b0, 1'b0, 5'h0B, 1'b1, 2'b00, 8'h32, 1'b0, 1'b0, 1'b1},
      '{1'b1, 1'b0, 5'h01, 1'b1, 2'b00, 8'h21, 1'b0, 1'b1, 1'b0},
      '{1'b1, 1'b0, 5'h0A, 1'b1, 2'b00, 8'h20, 1'b1, 1'b0, 1'b0},
      '{1'b1, 1'b0, 5'h08, 1'b0, 2'b10, 8'h20, 1'b1, 1'b1, 1'b1},
      '{1'b0, 1'b1, 5'h08, 1'b0, 2'b00, 8'h13, 1'b1, 1'b1, 1'b0},
      '{1'b0, 1'b1, 5'h00, 1'b1, 2'b01, 8'h10, 1'b1, 1'b1, 1'b0},
      '{1'b1, 1'b1, 5'h0F, 1'b1, 2'b00, 8'h01, 1'b0, 1'b0, 1'b1}
   };

   task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", what, act, exp);
      end
   endtask

   task automatic reg_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic reg_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #2 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0x00 expected 0x01 (run did not finish)");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;

      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      reg_read(1'b1, v);  check("R1 status after reset", v, 8'h00);
      reg_read(1'b0, v);  check("R1 control after reset", v, 8'h00);
      check("R1 dtr_no after reset", {7'd0, dtr_n}, 8'h01);
      check("R1 rts_no after reset", {7'd0, rts_n}, 8'h01);
      check("R1 irq_o after reset", {7'd0, irq}, 8'h00);

      // table walk: R2 R3 R4 R5 R7 R8
      for (int i = 0; i < NVEC; i++) begin
         reg_write(1'b0, {3'b000, VECS[i].ctrl});
         @(negedge clk);
         cts_n = VECS[i].cts_n; dsr_n = VECS[i].dsr_n;
         msi_en = VECS[i].msi; ext_req = VECS[i].ext;
         idle(4);
         check($sformatf("R5 dtr_no vec %0d", i), {7'd0, dtr_n}, {7'd0, VECS[i].dtr_n});
         check($sformatf("R5 rts_no vec %0d", i), {7'd0, rts_n}, {7'd0, VECS[i].rts_n});
         check($sformatf("R8 irq_o vec %0d", i), {7'd0, irq}, {7'd0, VECS[i].irq});
         reg_read(1'b0, v);
         check($sformatf("R7 control vec %0d", i), v, {3'b000, VECS[i].ctrl});
         reg_read(1'b1, v);
         check($sformatf("R2/R3 status vec %0d", i), v, VECS[i].stat);
      end

      // R2 latency: inputs high, ctrl 0x0F, msi 1, flags clear
      @(negedge clk);
      cts_n = 1'b0;
      @(negedge clk);
      addr = 1'b1; #2 check("R2 cts after one edge", rdata & 8'h10, 8'h00);
      @(negedge clk);
      #2 check("R2 cts after two edges", rdata & 8'h10, 8'h10);
      idle(2);
      check("R8 irq on modem change", {7'd0, irq}, 8'h01);
      reg_write(1'b0, 8'h07);
      check("R8 irq gated by bit 3", {7'd0, irq}, 8'h00);
      reg_write(1'b0, 8'h0F);
      check("R3 flag still set, irq back", {7'd0, irq}, 8'h01);
      idle(10);
      reg_read(1'b1, v);  check("R3 sticky flag read", v, 8'h11);
      check("R9 irq after service read", {7'd0, irq}, 8'h00);
      reg_read(1'b1, v);  check("R4 flag cleared by read", v, 8'h10);

      // R4 change in the same cycle as a status read
      @(negedge clk);
      dsr_n = 1'b0;
      @(negedge clk);
      reg_read(1'b1, v);  check("R4 read at change edge", v, 8'h30);
      reg_read(1'b1, v);  check("R4 change kept over clear", v, 8'h32);

      // R6 and R5 loop mode
      reg_write(1'b0, 8'h13);
      idle(3);
      check("R5 dtr_no inactive in loop", {7'd0, dtr_n}, 8'h01);
      check("R5 rts_no inactive in loop", {7'd0, rts_n}, 8'h01);
      reg_read(1'b1, v);
      @(negedge clk);
      cts_n = 1'b1; dsr_n = 1'b1;
      idle(5);
      reg_read(1'b1, v);  check("R6 loop ignores inputs", v, 8'h30);
      reg_write(1'b0, 8'h11);
      idle(2);
      reg_read(1'b1, v);  check("R6 loop shows control bits", v, 8'h21);

      // R7 upper write bits dropped
      reg_write(1'b0, 8'hE4);
      reg_read(1'b0, v);  check("R7 control readback masks high bits", v, 8'h04);

      // R1 reset in the middle of operation
      reg_write(1'b0, 8'h0B);
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(2);
      reg_read(1'b0, v);  check("R1 control after mid reset", v, 8'h00);
      check("R1 dtr_no after mid reset", {7'd0, dtr_n}, 8'h01);
      check("R1 rts_no after mid reset", {7'd0, rts_n}, 8'h01);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule